// File: doc/BRIEF.md
# ROM Emulation Bus Responder

This block answers internal-bus cycles aimed at an on-chip ROM. When a cycle-start strobe arrives, the block sorts the access by the hit flags from the address decoder: control register, bootstrap window, or ROM array. In normal operation it acknowledges the address and drives read data for one cycle. Register data comes from the register read port. Bootstrap and array data come from the ROM read port, which is addressed straight from the bus address.

When emulation is enabled and the module is not stopped, an array access is handed off to external logic. The block withholds the address acknowledge and raises an external chip-select request. It holds the data drivers off while it counts the wait states latched at cycle start, then ends the cycle with a single-cycle data-acknowledge pulse. An external device supplies the data. While that handed-off cycle is open, further cycle starts are dropped. Register and bootstrap accesses are answered in the same way in every mode. An array access made while the module is stopped gets no response of any kind.

Top module: `rom_emul_responder`

## Requirements
- R1: A cycle start with `reg_hit`=1, taken while no emulated cycle is open, gives `addr_ack`=1 and `data_oe`=1 for exactly the next cycle, with `data_out` equal to the `reg_rdata` value sampled at the start edge. The priority order is register hit, then bootstrap hit, then array hit.
- R2: A taken cycle start with `boot_hit`=1 (and `reg_hit`=0) gets the same one-cycle normal response, carrying `rom_rdata`, whatever the values of `emul_en` and `stop`.
- R3: A taken array access (`array_hit`=1, other hits 0) with `stop`=0 and `emul_en`=0 gets the one-cycle normal response carrying `rom_rdata`. `rom_addr` always equals `addr`.
- R4: A taken array access with `stop`=0 and `emul_en`=1 produces no `addr_ack`. `ext_cs_req` is high from the cycle after the start edge for W+1 cycles, where W is the `wait_cnt` value sampled at the start edge (0 to 3).
- R5: An emulated cycle ends with `data_ack` high for exactly one cycle, the last cycle of `ext_cs_req`. With W=0 that is the cycle right after the start edge. `ext_cs_req` is low in the following cycle.
- R6: `data_oe` is never high while `ext_cs_req` is high.
- R7: An array access with `stop`=1 produces no `addr_ack`, no `data_oe` and no `ext_cs_req`.
- R8: A cycle start of any kind that arrives while `ext_cs_req` is high, including the acknowledge cycle, is ignored. It produces no acknowledge, no data and no change to the open cycle.
- R9: Without a taken start, all outputs stay idle. `data_out` is 0 whenever `data_oe` is 0.
- R10: While `rst_n` is low, `addr_ack`, `data_oe`, `data_out`, `ext_cs_req` and `data_ack` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Bus cycle start strobe |
| addr | input | ADDR_W | Bus address |
| reg_hit | input | 1 | Address hits a control register |
| boot_hit | input | 1 | Address hits the bootstrap window |
| array_hit | input | 1 | Address hits the ROM array |
| emul_en | input | 1 | Emulation enable bit |
| stop | input | 1 | Module stopped |
| wait_cnt | input | WAIT_W | Extra wait cycles for emulated cycles |
| reg_rdata | input | DATA_W | Control register read data |
| rom_rdata | input | DATA_W | ROM read data for `rom_addr` |
| rom_addr | output | ADDR_W | ROM read address |
| addr_ack | output | 1 | Normal address acknowledge |
| data_oe | output | 1 | Data bus driver enable |
| data_out | output | DATA_W | Data driven onto the bus |
| ext_cs_req | output | 1 | External chip-select request |
| data_ack | output | 1 | Data acknowledge ending an emulated cycle |

## Verification
The bench builds the block with DATA_W=16, ADDR_W=24 and WAIT_W=2. With these values every wait count from 0 to 3 can be reached, so the widest acknowledge window is covered, and ROM data derived from the address can be told apart from register data. Directed cases cover each wait value and each bootstrap, stop and emulation combination. They also cover starts that land inside an open emulated cycle and on its acknowledge cycle. Random traffic then mixes all of these freely.

// File: rtl/rer_pkg.sv
package rer_pkg;

    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_REG   = 3'd1,
        ACC_BOOT  = 3'd2,
        ACC_ARRAY = 3'd3,
        ACC_EMUL  = 3'd4
    } acc_kind_e;

endpackage

// File: rtl/rer_decode.sv
module rer_decode
    import rer_pkg::*;
(
    input  logic      cyc_start,
    input  logic      busy,
    input  logic      reg_hit,
    input  logic      boot_hit,
    input  logic      array_hit,
    input  logic      emul_en,
    input  logic      stop,
    output acc_kind_e kind
);

    always_comb begin
        kind = ACC_NONE;
        if (cyc_start && !busy) begin
            if (reg_hit) begin
                kind = ACC_REG;
            end else if (boot_hit) begin
                kind = ACC_BOOT;
            end else if (array_hit) begin
                if (stop) begin
                    kind = ACC_NONE;
                end else if (emul_en) begin
                    kind = ACC_EMUL;
                end else begin
                    kind = ACC_ARRAY;
                end
            end
        end
    end

endmodule

// File: rtl/rer_wait_timer.sv
module rer_wait_timer
    import rer_pkg::*;
#(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic [WAIT_W-1:0] wait_cnt,
    output logic              busy,
    output logic              cs_req,
    output logic              dack
);

    typedef struct packed {
        logic              pend;
        logic [WAIT_W-1:0] left;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            if (st_q.left == '0) begin
                st_d.pend = 1'b0;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end else if (kind == ACC_EMUL) begin
            st_d.pend = 1'b1;
            st_d.left = wait_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.pend;
    assign cs_req = st_q.pend;
    assign dack   = st_q.pend && (st_q.left == '0);

endmodule

// File: rtl/rer_normal_resp.sv
module rer_normal_resp
    import rer_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              ack,
    output logic              oe,
    output logic [DATA_W-1:0] dout
);

    typedef struct packed {
        logic              ack;
        logic              oe;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t st_d, st_q;

    always_comb begin
        st_d = '0;
        case (kind)
            ACC_REG: begin
                st_d.ack  = 1'b1;
                st_d.oe   = 1'b1;
                st_d.data = reg_rdata;
            end
            ACC_BOOT, ACC_ARRAY: begin
                st_d.ack  = 1'b1;
                st_d.oe   = 1'b1;
                st_d.data = rom_rdata;
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack  = st_q.ack;
    assign oe   = st_q.oe;
    assign dout = st_q.data;

endmodule

// File: rtl/rom_emul_responder.sv
module rom_emul_responder
    import rer_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              reg_hit,
    input  logic              boot_hit,
    input  logic              array_hit,
    input  logic              emul_en,
    input  logic              stop,
    input  logic [WAIT_W-1:0] wait_cnt,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              addr_ack,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              ext_cs_req,
    output logic              data_ack
);

    acc_kind_e kind;
    logic      busy;

    assign rom_addr = addr;

    rer_decode u_decode (
        .cyc_start (cyc_start),
        .busy      (busy),
        .reg_hit   (reg_hit),
        .boot_hit  (boot_hit),
        .array_hit (array_hit),
        .emul_en   (emul_en),
        .stop      (stop),
        .kind      (kind)
    );

    rer_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .wait_cnt (wait_cnt),
        .busy     (busy),
        .cs_req   (ext_cs_req),
        .dack     (data_ack)
    );

    rer_normal_resp #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .reg_rdata (reg_rdata),
        .rom_rdata (rom_rdata),
        .ack       (addr_ack),
        .oe        (data_oe),
        .dout      (data_out)
    );

endmodule

// File: rtl/rom_emul_responder_chk.sv
module rom_emul_responder_chk #(
    parameter int DATA_W = 16,
    parameter int WAIT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_start,
    input logic              reg_hit,
    input logic              boot_hit,
    input logic              array_hit,
    input logic              stop,
    input logic              addr_ack,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_out,
    input logic              ext_cs_req,
    input logic              data_ack
);

    localparam int RUN_W    = WAIT_W + 1;
    localparam int MAX_WAIT = (1 << WAIT_W) - 1;

    logic [RUN_W-1:0] cs_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_run <= '0;
        end else if (ext_cs_req) begin
            cs_run <= cs_run + 1'b1;
        end else begin
            cs_run <= '0;
        end
    end

    p_reg_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start && reg_hit && !ext_cs_req |=> addr_ack && data_oe);

    p_no_aack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cs_req |-> !addr_ack);

    p_dack_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_ack |-> ext_cs_req);

    p_dack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_ack |=> !data_ack && !ext_cs_req);

    p_cs_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cs_req |-> (int'(cs_run) <= MAX_WAIT));

    p_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cs_req |-> !data_oe);

    p_stop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start && array_hit && !reg_hit && !boot_hit && stop && !ext_cs_req
        |=> !addr_ack && !data_oe && !ext_cs_req);

    p_hold_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cs_req && !data_ack |=> ext_cs_req && !addr_ack);

    p_idle_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> data_out == '0);

endmodule

bind rom_emul_responder rom_emul_responder_chk #(
    .DATA_W (DATA_W),
    .WAIT_W (WAIT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .reg_hit    (reg_hit),
    .boot_hit   (boot_hit),
    .array_hit  (array_hit),
    .stop       (stop),
    .addr_ack   (addr_ack),
    .data_oe    (data_oe),
    .data_out   (data_out),
    .ext_cs_req (ext_cs_req),
    .data_ack   (data_ack)
);

// File: tb/rom_emul_responder_tb_top.sv
module rom_emul_responder_tb_top;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int WAIT_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cyc_start = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              reg_hit = 1'b0;
    logic              boot_hit = 1'b0;
    logic              array_hit = 1'b0;
    logic              emul_en = 1'b0;
    logic              stop = 1'b0;
    logic [WAIT_W-1:0] wait_cnt = '0;
    logic [DATA_W-1:0] reg_rdata = '0;
    logic [DATA_W-1:0] rom_rdata;
    logic [ADDR_W-1:0] rom_addr;
    logic              addr_ack;
    logic              data_oe;
    logic [DATA_W-1:0] data_out;
    logic              ext_cs_req;
    logic              data_ack;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // model state
    bit              m_pend = 1'b0;
    int              m_left = 0;

    always #10 clk = ~clk;

    function automatic logic [DATA_W-1:0] romf(input logic [ADDR_W-1:0] a);
        return a[DATA_W-1:0] ^ {a[ADDR_W-1:ADDR_W-8], 8'h5A};
    endfunction

    assign rom_rdata = romf(rom_addr);

    rom_emul_responder #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WAIT_W (WAIT_W)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_start  (cyc_start),
        .addr       (addr),
        .reg_hit    (reg_hit),
        .boot_hit   (boot_hit),
        .array_hit  (array_hit),
        .emul_en    (emul_en),
        .stop       (stop),
        .wait_cnt   (wait_cnt),
        .reg_rdata  (reg_rdata),
        .rom_rdata  (rom_rdata),
        .rom_addr   (rom_addr),
        .addr_ack   (addr_ack),
        .data_oe    (data_oe),
        .data_out   (data_out),
        .ext_cs_req (ext_cs_req),
        .data_ack   (data_ack)
    );

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Drive one cycle (called just after a falling edge), then check after the next falling edge.
    task automatic step(input bit st, input bit rh, input bit bh, input bit ah,
                        input bit em, input bit sp, input int w,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] rd);
        string tag;
        bit e_ack, e_cs, e_dack;
        logic [DATA_W-1:0] e_data;
        cyc_start = st; reg_hit = rh; boot_hit = bh; array_hit = ah;
        emul_en = em; stop = sp; wait_cnt = WAIT_W'(w); addr = a; reg_rdata = rd;
        check("R3", "rom_addr", rom_addr, a);
        e_ack = 1'b0; e_data = '0; tag = "R9";
        if (m_pend) begin
            tag = st ? "R8" : "R5";
            if (m_left == 0) m_pend = 1'b0;
            else m_left--;
        end else if (st) begin
            if (rh) begin
                e_ack = 1'b1; e_data = rd; tag = "R1";
            end else if (bh) begin
                e_ack = 1'b1; e_data = romf(a); tag = "R2";
            end else if (ah) begin
                if (sp) tag = "R7";
                else if (em) begin
                    m_pend = 1'b1; m_left = w; tag = "R4";
                end else begin
                    e_ack = 1'b1; e_data = romf(a); tag = "R3";
                end
            end
        end
        e_cs   = m_pend;
        e_dack = m_pend && (m_left == 0);
        @(posedge clk);
        @(negedge clk);
        check(tag, "addr_ack", addr_ack, e_ack);
        check(tag, "data_oe", data_oe, e_ack);
        check(tag, "data_out", data_out, e_data);
        check(e_cs ? "R4" : tag, "ext_cs_req", ext_cs_req, e_cs);
        check(e_cs ? "R5" : tag, "data_ack", data_ack, e_dack);
        check("R6", "oe_with_cs", data_oe && ext_cs_req, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 24'h0, 16'h0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "addr_ack", addr_ack, 0);
        check("R10", "data_oe", data_oe, 0);
        check("R10", "data_out", data_out, 0);
        check("R10", "ext_cs_req", ext_cs_req, 0);
        check("R10", "data_ack", data_ack, 0);
        rst_n = 1'b1;
        idle(2);
        // R1 register read, also under emulation and stop
        step(1, 1, 0, 0, 0, 0, 0, 24'h000010, 16'hBEEF);
        step(1, 1, 0, 1, 1, 0, 3, 24'h000012, 16'h1234);
        step(1, 1, 0, 1, 1, 1, 2, 24'h000014, 16'h4321);
        // R2 bootstrap regardless of emulation/stop
        step(1, 0, 1, 1, 1, 0, 1, 24'h123456, 16'h0);
        step(1, 0, 1, 1, 0, 1, 1, 24'hABCDEF, 16'h0);
        // R3 normal array read
        step(1, 0, 0, 1, 0, 0, 2, 24'h7F00AA, 16'h0);
        idle(1);
        // R4/R5 emulated cycles with each wait count
        for (int w = 0; w < 4; w++) begin
            step(1, 0, 0, 1, 1, 0, w, 24'h300000 + w, 16'h0);
            idle(w + 2);
        end
        // R8 starts inside an open emulated cycle, including the ack cycle
        step(1, 0, 0, 1, 1, 0, 2, 24'h400000, 16'h0);
        step(1, 1, 0, 0, 0, 0, 0, 24'h000010, 16'hCAFE);
        step(1, 0, 1, 0, 0, 0, 0, 24'h000020, 16'h0);
        step(1, 0, 0, 1, 1, 0, 3, 24'h400004, 16'h0);
        step(1, 1, 0, 0, 0, 0, 0, 24'h000010, 16'hF00D);
        // R7 stopped array access, emulation on and off
        step(1, 0, 0, 1, 1, 1, 1, 24'h500000, 16'h0);
        step(1, 0, 0, 1, 0, 1, 1, 24'h500002, 16'h0);
        idle(2);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 3) != 0, ($urandom % 4) == 0, ($urandom % 5) == 0,
                 ($urandom % 3) != 0, ($urandom % 2) == 1, ($urandom % 5) == 0,
                 int'($urandom % 4), ADDR_W'($urandom), DATA_W'($urandom));
        end
        idle(6);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule